// File: doc/BRIEF.md
# Programmable Interrupt Routing Matrix

This block gathers a set of peripheral interrupt request lines and folds them onto the seven prioritized general-purpose request inputs of a processor core. Each source carries its own enable bit and its own routing field. The routing field names the core request level that the source drives. Each of the seven outputs is a level request: the OR of every enabled, active source routed to that level, registered once before it leaves the block. The two lowest core priorities are never driven from here, because they are kept for software-raised interrupts.

Software programs the block through a small word-wide register port. Writes are synchronous and take effect at the clock edge that samples them. Reads are combinational from the address. One word holds the enable bits. A read-only word returns the raw source lines whatever their enable state. The remaining words pack the routing fields, eight 4-bit fields per 32-bit word. After reset every source is disabled, and every routing field holds a default assignment that spreads the sources round-robin over the levels.

Top module: `irq_route_matrix`

## Requirements
- R1: While reset is held and on the first cycle after it, `lvl_req_o` is all zero and the enable word (address 0) reads zero.
- R2: After reset, routing field of source s (bits [4*(s%8)+3 : 4*(s%8)] of address 2 + s/8) reads s mod 7.
- R3: A source whose enable bit (bit s of address 0, 1 = enabled) is 0 never raises any output, whatever its level.
- R4: Output bit k is the OR of all enabled sources whose routing field equals k (0 to 6, meaning core levels 7 to 13), sampled at the previous clock edge.
- R5: A routing field value from 7 to 15 disconnects its source: it drives no output.
- R6: A register write is visible in register reads right after the edge that samples it. The outputs reflect it one edge later.
- R7: A read of address 1 returns the raw source lines in bits [15:0], independent of the enable bits, with the upper bits zero.
- R8: Writes to address 1 or to unused addresses change no register. Unused addresses read zero, and routing words read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 16 | Peripheral interrupt request levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| lvl_req_o | output | 7 | Registered request lines for core levels 7 to 13 (bit 0 = level 7) |

## Verification
On every cycle the assertions check the following. Outputs are quiet after reset. No output rises unless some enabled source was active one edge earlier. The count of raised levels never exceeds the count of enabled active sources. An enable write lands on the next edge. The status word mirrors the raw lines, and a write to it leaves the enables alone. The exact routing, the disconnect codes and the one-cycle gap between a register update and the output can only be shown by the bench's scenarios. The bench sweeps every field value for every source and many source patterns under varied routing, and compares each result against its arithmetic model.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned REG_MASK = 0;
   localparam int unsigned REG_STAT = 1;
   localparam int unsigned REG_MAP0 = 2;

   // reset routing: spread sources round-robin over the levels
   function automatic int unsigned default_level(input int unsigned src, input int unsigned nlvl);
      return src % nlvl;
   endfunction
endpackage

// File: rtl/irqmap_regs.sv
module irqmap_regs
   import irqmap_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned NUM_LVL = 7,
   parameter int unsigned MAP_W   = 4,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_SRC-1:0]       src_i,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic [NUM_SRC-1:0]       mask_o,
   output logic [NUM_SRC*MAP_W-1:0] map_o
);
   localparam int unsigned FPW       = DATA_W / MAP_W;
   localparam int unsigned MAP_WORDS = (NUM_SRC + FPW - 1) / FPW;

   logic [NUM_SRC-1:0] mask_q;
   logic               wr_mask;

   assign wr_mask = wr_en && (wr_addr == ADDR_W'(REG_MASK));

   always_ff @(posedge clk) begin
      if (rst)          mask_q <= '0;
      else if (wr_mask) mask_q <= wr_data[NUM_SRC-1:0];
   end
   assign mask_o = mask_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
      localparam int unsigned WIDX = s / FPW;
      localparam int unsigned FIDX = s % FPW;
      logic [MAP_W-1:0] fld_q;
      logic             fld_we;
      assign fld_we = wr_en && (wr_addr == ADDR_W'(REG_MAP0 + WIDX));
      always_ff @(posedge clk) begin
         if (rst)         fld_q <= MAP_W'(default_level(s, NUM_LVL));
         else if (fld_we) fld_q <= wr_data[FIDX*MAP_W +: MAP_W];
      end
      assign map_o[s*MAP_W +: MAP_W] = fld_q;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_MASK)) begin
         rd_data[NUM_SRC-1:0] = mask_q;
      end else if (rd_addr == ADDR_W'(REG_STAT)) begin
         rd_data[NUM_SRC-1:0] = src_i;
      end else begin
         for (int w = 0; w < int'(MAP_WORDS); w++) begin
            if (rd_addr == ADDR_W'(int'(REG_MAP0) + w)) begin
               for (int f = 0; f < int'(FPW); f++) begin
                  if (w * int'(FPW) + f < int'(NUM_SRC))
                     rd_data[f*MAP_W +: MAP_W] = map_o[(w*int'(FPW)+f)*MAP_W +: MAP_W];
               end
            end
         end
      end
   end

   // R6: an enable write is in place after the sampling edge
   a_r6_mask_lands: assert property (@(posedge clk) disable iff (rst)
      wr_mask |=> mask_o == $past(wr_data[NUM_SRC-1:0]));

   // R7: status word mirrors the raw request lines
   a_r7_status_raw: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == ADDR_W'(REG_STAT)) |-> rd_data == DATA_W'(src_i));

   // R8: a write to the status word leaves the enables untouched
   a_r8_status_ro: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(REG_STAT)) |=> $stable(mask_o));
endmodule

// File: rtl/irqmap_matrix.sv
module irqmap_matrix #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned NUM_LVL = 7,
   parameter int unsigned MAP_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_SRC-1:0]       src_i,
   input  logic [NUM_SRC-1:0]       mask_i,
   input  logic [NUM_SRC*MAP_W-1:0] map_i,
   output logic [NUM_LVL-1:0]       lvl_o
);
   logic [NUM_SRC-1:0] live;
   assign live = src_i & mask_i;

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      logic [NUM_SRC-1:0] hit;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign hit[s] = live[s] && (map_i[s*MAP_W +: MAP_W] == MAP_W'(l));
      end
      assign lvl_o[l] = |hit;
   end

   // R4: every raised level needs its own live source
   a_r4_fanout: assert property (@(posedge clk) disable iff (rst)
      $countones(lvl_o) <= $countones(live));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
   import irqmap_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned NUM_LVL = 7,
   parameter int unsigned MAP_W   = 4,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [WORD_W-1:0]  rd_data,
   output logic [NUM_LVL-1:0] lvl_req_o
);
   localparam int unsigned FPW       = WORD_W / MAP_W;
   localparam int unsigned MAP_WORDS = (NUM_SRC + FPW - 1) / FPW;

   if (NUM_SRC > WORD_W || NUM_SRC == 0) begin : g_bad_src
      $error("NUM_SRC must be between 1 and the register width");
   end
   if (NUM_LVL >= (1 << MAP_W)) begin : g_bad_lvl
      $error("MAP_W too narrow to hold a disconnect code");
   end
   if ((WORD_W % MAP_W) != 0) begin : g_bad_fld
      $error("MAP_W must divide the register width");
   end
   if (REG_MAP0 + MAP_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_SRC-1:0]       mask;
   logic [NUM_SRC*MAP_W-1:0] map;
   logic [NUM_LVL-1:0]       lvl_next;
   logic [NUM_LVL-1:0]       lvl_q;

   irqmap_regs #(
      .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .MAP_W(MAP_W),
      .ADDR_W(ADDR_W), .DATA_W(WORD_W)
   ) u_regs (
      .clk(clk), .rst(rst), .src_i(src_i),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .mask_o(mask), .map_o(map)
   );

   irqmap_matrix #(
      .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .MAP_W(MAP_W)
   ) u_matrix (
      .clk(clk), .rst(rst), .src_i(src_i), .mask_i(mask),
      .map_i(map), .lvl_o(lvl_next)
   );

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl_next;
   end
   assign lvl_req_o = lvl_q;

   // R1: outputs are quiet on the cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> lvl_req_o == '0);

   // R3: nothing is requested unless an enabled source was active
   a_r3_masked_silent: assert property (@(posedge clk) disable iff (rst)
      (|lvl_req_o) |-> (|$past(src_i & mask)));
endmodule

// File: tb/irq_route_matrix_bench.sv
module irq_route_matrix_bench;
   localparam int NS = 16;
   localparam int NL = 7;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] src = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [6:0]  lvl;

   int checks = 0;
   int fails  = 0;

   logic [3:0]  map_m [NS];
   logic [15:0] mask_m = '0;
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk = ~clk;

   irq_route_matrix u_irq_route_matrix (
      .clk(clk), .rst(rst), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .lvl_req_o(lvl)
   );

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      report();
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [6:0] model(input logic [15:0] s);
      logic [6:0] r = '0;
      for (int i = 0; i < NS; i++)
         if (s[i] && mask_m[i] && map_m[i] < 4'(NL)) r[map_m[i]] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] pack_word(input int w);
      logic [31:0] d = '0;
      for (int f = 0; f < 8; f++) d[f*4 +: 4] = map_m[w*8+f];
      return d;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic push_map();
      wr(4'd2, pack_word(0));
      wr(4'd3, pack_word(1));
   endtask

   function automatic logic [31:0] next_rand();
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      return seed;
   endfunction

   initial begin
      logic [31:0] d;
      for (int i = 0; i < NS; i++) map_m[i] = 4'(i % NL);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 lvl during reset", 32'(lvl), 32'h0);
      rst = 1'b0;
      step();
      check("R1 lvl after reset", 32'(lvl), 32'h0);
      rd(4'd0, d); check("R1 enable word", d, 32'h0);
      // R2: default routing
      rd(4'd2, d); check("R2 default word 0", d, pack_word(0));
      rd(4'd3, d); check("R2 default word 1", d, pack_word(1));

      // R3: all disabled, all active
      src = 16'hFFFF; step(); step();
      check("R3 disabled sources", 32'(lvl), 32'h0);

      // R6: enable write visible in read at once, outputs one edge later
      src = 16'h0001;
      wr(4'd0, 32'h0000_0001); mask_m = 16'h0001;
      rd(4'd0, d); check("R6 enable readback", d, 32'h1);
      check("R6 output not yet updated", 32'(lvl), 32'h0);
      step();
      check("R6 output after one edge", 32'(lvl), 32'h1);

      // R4: walk one source at a time under default routing
      wr(4'd0, 32'h0000_FFFF); mask_m = 16'hFFFF;
      for (int s = 0; s < NS; s++) begin
         src = 16'(1 << s); step();
         check("R4 single source default map", 32'(lvl), 32'(model(src)));
      end

      // R4/R5: every field value for every source
      for (int s = 0; s < NS; s++) begin
         for (int v = 0; v < 16; v++) begin
            for (int i = 0; i < NS; i++) map_m[i] = 4'hF;
            map_m[s] = 4'(v);
            push_map();
            src = 16'hFFFF; step();
            check(v < NL ? "R4 field sweep" : "R5 disconnect code",
                  32'(lvl), v < NL ? 32'(1 << v) : 32'h0);
            rd(4'(2 + s / 8), d);
            check("R8 routing readback", d, pack_word(s / 8));
         end
      end

      // R7: status returns raw lines regardless of enables
      wr(4'd0, 32'h0); mask_m = '0;
      for (int k = 0; k < 24; k++) begin
         src = next_rand()[15:0];
         rd(4'd1, d); check("R7 status raw", d, 32'(src));
      end

      // R8: write to status and unused addresses changes nothing
      wr(4'd0, 32'h0000_A5C3); mask_m = 16'hA5C3;
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd0, d); check("R8 status write ignored", d, 32'h0000_A5C3);
      for (int a = 4; a < 16; a++) begin
         wr(4'(a), 32'hFFFF_FFFF);
         rd(4'(a), d); check("R8 unused reads zero", d, 32'h0);
      end
      rd(4'd0, d); check("R8 enable word kept", d, 32'h0000_A5C3);
      rd(4'd2, d); check("R8 routing word kept", d, pack_word(0));

      // R3/R4: random routing and enables, swept source patterns
      for (int c = 0; c < 8; c++) begin
         for (int i = 0; i < NS; i++) map_m[i] = 4'(next_rand() % 10);
         mask_m = next_rand()[15:0];
         push_map();
         wr(4'd0, 32'(mask_m));
         for (int p = 0; p < 65536; p += 131) begin
            src = 16'(p);
            step();
            check("R4 random routing sweep", 32'(lvl), 32'(model(src)));
         end
      end

      // R1: reset again clears outputs and enables, restores routing
      src = 16'hFFFF; rst = 1'b1; step(); rst = 1'b0;
      for (int i = 0; i < NS; i++) map_m[i] = 4'(i % NL);
      check("R1 lvl after second reset", 32'(lvl), 32'h0);
      rd(4'd0, d); check("R1 enable word after second reset", d, 32'h0);
      rd(4'd3, d); check("R2 default restored", d, pack_word(1));
      report();
   end
endmodule